// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Issuer

This block is the sending half of a per-core interrupt controller. Software on the owning core fills in a two-word command: a high word with a physical destination ID, and a low word with an interrupt vector, a delivery mode and a destination shorthand. Writing the low word launches the command.

The block works out which of the `NCORES` endpoints are targeted. Endpoint `i` has ID `i`, and the sending core is endpoint `SELF_ID`. It then presents the vector to each targeted endpoint on a point-to-point valid line. A line stays up until that endpoint returns a one-cycle accept pulse. A delivery-status bit in the low word reads 1 while any targeted endpoint has not yet accepted.

Two delivery modes are supported:
- **Fixed delivery** hands the vector to every addressed endpoint.
- **Lowest-priority delivery** picks exactly one endpoint. It first looks for an endpoint that is already servicing the same vector (the focus core). If there is none, it takes the one with the smallest task priority.

Top module: `ipi_sender`

## Requirements
- R1: After reset both command words read zero. The low word reads back the vector in bits 7:0, the delivery mode in bits 10:8, delivery status in bit 12 and the shorthand in bits 19:18. The high word reads back the destination ID in bits 31:24. All other bits read 0.
- R2: A low-word write (`wr_sel`=0) while delivery status is 0 starts a send. From the next cycle, delivery status reads 1, `msg_valid` is high for each targeted endpoint, and `msg_vector` carries the written vector.
- R3: With shorthand 2'b00 and fixed mode (3'b000), only the endpoint whose index equals the destination ID is targeted. A destination ID of `NCORES` or more targets nobody: delivery status stays 0 and no `msg_valid` rises.
- R4: Shorthand 2'b01 targets only endpoint `SELF_ID`. Shorthand 2'b10 targets every endpoint. Shorthand 2'b11 targets every endpoint except `SELF_ID`. With any nonzero shorthand the destination ID is ignored.
- R5: In lowest-priority mode (3'b001) exactly one addressed endpoint is targeted. If any addressed endpoint has `core_svc_act` set and `core_svc_vec` equal to the vector, the lowest-index such endpoint wins, whatever the priorities.
- R6: In lowest-priority mode with no focus endpoint, the addressed endpoint with the smallest `core_tpr` value is targeted. Equal values go to the lowest index.
- R7: A `msg_valid` bit stays high until its endpoint pulses `ep_accept`. It is low from the cycle after that pulse.
- R8: Delivery status stays 1 until every targeted endpoint has accepted, and reads 0 in the cycle after the last accept. Accept pulses from endpoints that are not pending have no effect.
- R9: A low-word write while delivery status is 1 is ignored: the stored low word and the pending messages are unchanged. High-word writes always take effect.
- R10: Delivery mode codes other than 3'b001 are handled as fixed delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Command register write strobe |
| wr_sel | input | 1 | 0 selects the low word, 1 the high word |
| wr_data | input | 32 | Write data |
| rd_lo | output | 32 | Low command word readback, including delivery status |
| rd_hi | output | 32 | High command word readback |
| core_tpr | input | NCORES*8 | Task priority of each endpoint, endpoint i at bits 8i+7:8i |
| core_svc_act | input | NCORES | Endpoint is servicing an interrupt |
| core_svc_vec | input | NCORES*8 | Vector each endpoint is servicing |
| msg_valid | output | NCORES | Message pending for each endpoint |
| msg_vector | output | 8 | Vector carried by the pending message |
| ep_accept | input | NCORES | One-cycle accept pulse from each endpoint |

## Verification
The bench builds the block with `NCORES`=4 and `SELF_ID`=1. With the sender in the middle of the index range, the exclude-self shorthand has to skip an interior endpoint. It also lets a lowest-index tie-break land on an endpoint other than 0 once the sender is removed. Four endpoints are enough for focus-versus-priority contests with several candidates, for two focus cores at once, and for a destination ID that falls outside the endpoint range.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    typedef enum logic [1:0] {
        SH_NONE   = 2'b00,
        SH_SELF   = 2'b01,
        SH_ALL    = 2'b10,
        SH_OTHERS = 2'b11
    } shorthand_e;

    localparam logic [2:0] DM_FIXED  = 3'b000;
    localparam logic [2:0] DM_LOWEST = 3'b001;

    localparam int VEC_LSB    = 0;
    localparam int MODE_LSB   = 8;
    localparam int STATUS_BIT = 12;
    localparam int SH_LSB     = 18;
    localparam int DEST_LSB   = 24;

    localparam int VW  = 8;
    localparam int IDW = 8;

endpackage

// File: rtl/ipi_dest_decode.sv
module ipi_dest_decode
    import ipi_pkg::*;
#(
    parameter int NCORES  = 4,
    parameter int SELF_ID = 0
) (
    input  shorthand_e         sh,
    input  logic [IDW-1:0]     dest,
    output logic [NCORES-1:0]  addr_mask
);

    for (genvar i = 0; i < NCORES; i++) begin : g_ep
        localparam logic [IDW-1:0] MY_ID = IDW'(i);
        localparam logic           IS_SELF = (i == SELF_ID);
        assign addr_mask[i] = (sh == SH_NONE)   ? (dest == MY_ID) :
                              (sh == SH_SELF)   ? IS_SELF :
                              (sh == SH_ALL)    ? 1'b1 :
                                                  !IS_SELF;
    end

endmodule

// File: rtl/ipi_lowpri_arb.sv
module ipi_lowpri_arb
    import ipi_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int PW     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCORES-1:0]    cand,
    input  logic [VW-1:0]        vec,
    input  logic [NCORES-1:0]    svc_act,
    input  logic [NCORES*VW-1:0] svc_vec,
    input  logic [NCORES*PW-1:0] tpr,
    output logic [NCORES-1:0]    pick
);

    localparam int IXW = (NCORES > 1) ? $clog2(NCORES) : 1;

    logic [PW-1:0]     tpr_a [NCORES];
    logic [NCORES-1:0] focus;

    for (genvar i = 0; i < NCORES; i++) begin : g_slot
        assign tpr_a[i] = tpr[i*PW +: PW];
        assign focus[i] = cand[i] && svc_act[i] && (svc_vec[i*VW +: VW] == vec);
    end

    logic           found;
    logic [IXW-1:0] best_idx;
    logic [PW-1:0]  best_tpr;

    always_comb begin
        found    = 1'b0;
        best_idx = '0;
        best_tpr = '1;
        pick     = '0;
        for (int i = 0; i < NCORES; i++) begin
            if (focus[i] && !found) begin
                found    = 1'b1;
                best_idx = IXW'(i);
            end
        end
        if (!found) begin
            for (int i = 0; i < NCORES; i++) begin
                if (cand[i] && (!found || (tpr_a[i] < best_tpr))) begin
                    found    = 1'b1;
                    best_tpr = tpr_a[i];
                    best_idx = IXW'(i);
                end
            end
        end
        if (found) begin
            pick[best_idx] = 1'b1;
        end
    end

    AST_PICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick) && ((|cand) -> (|pick))); // R5
    AST_FOCUS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(cand & svc_act)) && (|focus) |-> (|(pick & focus))); // R5

endmodule

// File: rtl/ipi_sender.sv
module ipi_sender
    import ipi_pkg::*;
#(
    parameter int NCORES  = 4,
    parameter int SELF_ID = 0,
    parameter int PW      = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [31:0]          wr_data,
    output logic [31:0]          rd_lo,
    output logic [31:0]          rd_hi,
    input  logic [NCORES*PW-1:0] core_tpr,
    input  logic [NCORES-1:0]    core_svc_act,
    input  logic [NCORES*VW-1:0] core_svc_vec,
    output logic [NCORES-1:0]    msg_valid,
    output logic [VW-1:0]        msg_vector,
    input  logic [NCORES-1:0]    ep_accept
);

    typedef struct packed {
        logic [VW-1:0]     vec;
        logic [2:0]        mode;
        shorthand_e        sh;
        logic [IDW-1:0]    dest;
        logic [NCORES-1:0] pend;
    } state_t;

    state_t st_d, st_q;

    logic              busy;
    logic              start;
    shorthand_e        wr_sh;
    logic [2:0]        wr_mode;
    logic [VW-1:0]     wr_vec;
    logic [NCORES-1:0] addr_mask;
    logic [NCORES-1:0] lp_pick;
    logic [NCORES-1:0] tgt_mask;
    logic              unused_bits;

    assign wr_sh       = shorthand_e'(wr_data[SH_LSB +: 2]);
    assign wr_mode     = wr_data[MODE_LSB +: 3];
    assign wr_vec      = wr_data[VEC_LSB +: VW];
    assign unused_bits = ^{wr_data[23:20], wr_data[17:11]};

    assign busy  = |st_q.pend;
    assign start = wr_en && !wr_sel && !busy;

    ipi_dest_decode #(
        .NCORES  (NCORES),
        .SELF_ID (SELF_ID)
    ) u_decode (
        .sh        (wr_sh),
        .dest      (st_q.dest),
        .addr_mask (addr_mask)
    );

    ipi_lowpri_arb #(
        .NCORES (NCORES),
        .PW     (PW)
    ) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .cand    (addr_mask),
        .vec     (wr_vec),
        .svc_act (core_svc_act),
        .svc_vec (core_svc_vec),
        .tpr     (core_tpr),
        .pick    (lp_pick)
    );

    assign tgt_mask = (wr_mode == DM_LOWEST) ? lp_pick : addr_mask;

    always_comb begin
        st_d      = st_q;
        st_d.pend = st_q.pend & ~ep_accept;
        if (wr_en && wr_sel) begin
            st_d.dest = wr_data[DEST_LSB +: IDW];
        end
        if (start) begin
            st_d.vec  = wr_vec;
            st_d.mode = wr_mode;
            st_d.sh   = wr_sh;
            st_d.pend = tgt_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign msg_valid  = st_q.pend;
    assign msg_vector = st_q.vec;
    assign rd_lo      = {12'b0, st_q.sh, 5'b0, busy, 1'b0, st_q.mode, st_q.vec};
    assign rd_hi      = {st_q.dest, 24'b0};

    AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((msg_valid & $past(msg_valid & ~ep_accept)) == $past(msg_valid & ~ep_accept))); // R7
    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && wr_en && !wr_sel |=> $stable(st_q.vec) && $stable(st_q.mode) && $stable(st_q.sh)); // R9
    AST_STATUS_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        busy && ((msg_valid & ~ep_accept) == '0) |=> !rd_lo[STATUS_BIT]); // R8
    AST_OTHERS_SKIPS_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        start && (wr_sh == SH_OTHERS) |=> !msg_valid[SELF_ID]); // R4
    AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> !rd_lo[STATUS_BIT] && (msg_valid == '0)); // R8

endmodule

// File: tb/sim_ipi_sender.sv
module sim_ipi_sender;

    localparam int N = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_lo, rd_hi;
    logic [N*8-1:0] core_tpr = '0;
    logic [N-1:0]  core_svc_act = '0;
    logic [N*8-1:0] core_svc_vec = '0;
    logic [N-1:0]  msg_valid;
    logic [7:0]    msg_vector;
    logic [N-1:0]  ep_accept = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ipi_sender #(.NCORES(N), .SELF_ID(1), .PW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .core_tpr(core_tpr), .core_svc_act(core_svc_act),
        .core_svc_vec(core_svc_vec), .msg_valid(msg_valid), .msg_vector(msg_vector),
        .ep_accept(ep_accept)
    );

    function automatic logic [31:0] lo(input logic [7:0] v, input logic [2:0] m, input logic [1:0] s);
        return {12'b0, s, 5'b0, 1'b0, 1'b0, m, v};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic acc(input logic [N-1:0] m);
        @(negedge clk);
        ep_accept = m;
        @(negedge clk);
        ep_accept = '0;
    endtask

    task automatic t_reset;
        chk("R1 reset lo", rd_lo, 32'h0);
        chk("R1 reset hi", rd_hi, 32'h0);
        chk("R1 reset valid", {28'b0, msg_valid}, 32'h0);
    endtask

    task automatic t_fixed;
        wr(1'b1, 32'h0200_0000);
        chk("R1 hi readback", rd_hi, 32'h0200_0000);
        wr(1'b0, lo(8'h40, 3'b000, 2'b00));
        chk("R3 fixed target", {28'b0, msg_valid}, 32'h4);
        chk("R2 vector", {24'b0, msg_vector}, 32'h40);
        chk("R1 R2 lo with status", rd_lo, lo(8'h40, 3'b000, 2'b00) | 32'h1000);
        repeat (3) @(negedge clk);
        chk("R7 held", {28'b0, msg_valid}, 32'h4);
        acc(4'b0001);
        chk("R8 stray accept", {28'b0, msg_valid}, 32'h4);
        chk("R8 stray accept status", {31'b0, rd_lo[12]}, 32'h1);
        acc(4'b0100);
        chk("R7 dropped", {28'b0, msg_valid}, 32'h0);
        chk("R8 status clear", {31'b0, rd_lo[12]}, 32'h0);
    endtask

    task automatic t_busy_ignore;
        wr(1'b0, lo(8'h40, 3'b000, 2'b00));
        wr(1'b0, lo(8'h33, 3'b000, 2'b11));
        chk("R9 lo kept", rd_lo, lo(8'h40, 3'b000, 2'b00) | 32'h1000);
        chk("R9 msgs kept", {28'b0, msg_valid}, 32'h4);
        wr(1'b1, 32'h0300_0000);
        chk("R9 hi taken", rd_hi, 32'h0300_0000);
        acc(4'b0100);
        chk("R9 idle after", {31'b0, rd_lo[12]}, 32'h0);
    endtask

    task automatic t_shorthand;
        wr(1'b0, lo(8'h21, 3'b000, 2'b01));
        chk("R4 self", {28'b0, msg_valid}, 32'h2);
        acc(4'b0010);
        wr(1'b0, lo(8'h22, 3'b000, 2'b10));
        chk("R4 all", {28'b0, msg_valid}, 32'hF);
        acc(4'b0011);
        chk("R8 partial", {28'b0, msg_valid}, 32'hC);
        chk("R8 partial status", {31'b0, rd_lo[12]}, 32'h1);
        acc(4'b1100);
        chk("R8 all done", {31'b0, rd_lo[12]}, 32'h0);
        wr(1'b0, lo(8'h23, 3'b000, 2'b11));
        chk("R4 others", {28'b0, msg_valid}, 32'hD);
        acc(4'b1101);
    endtask

    task automatic t_nobody;
        wr(1'b1, 32'h0900_0000);
        wr(1'b0, lo(8'h30, 3'b000, 2'b00));
        chk("R3 out of range valid", {28'b0, msg_valid}, 32'h0);
        chk("R3 out of range status", {31'b0, rd_lo[12]}, 32'h0);
    endtask

    task automatic t_reserved;
        wr(1'b1, 32'h0000_0000);
        wr(1'b0, lo(8'h31, 3'b101, 2'b00));
        chk("R10 reserved as fixed", {28'b0, msg_valid}, 32'h1);
        acc(4'b0001);
    endtask

    task automatic t_focus;
        core_tpr = {8'd9, 8'd9, 8'd0, 8'd5};
        core_svc_act = 4'b1000;
        core_svc_vec = {8'h50, 8'h00, 8'h00, 8'h00};
        wr(1'b0, lo(8'h50, 3'b001, 2'b10));
        chk("R5 focus wins", {28'b0, msg_valid}, 32'h8);
        acc(4'b1000);
        wr(1'b0, lo(8'h51, 3'b001, 2'b10));
        chk("R6 no matching focus", {28'b0, msg_valid}, 32'h2);
        acc(4'b0010);
        core_svc_act = 4'b0110;
        core_svc_vec = {8'h00, 8'h70, 8'h70, 8'h00};
        wr(1'b0, lo(8'h70, 3'b001, 2'b10));
        chk("R5 two focus lowest", {28'b0, msg_valid}, 32'h2);
        acc(4'b0010);
        core_svc_act = '0;
    endtask

    task automatic t_tie;
        core_tpr = {8'd9, 8'd2, 8'd2, 8'd6};
        wr(1'b0, lo(8'h60, 3'b001, 2'b10));
        chk("R6 tie lowest id", {28'b0, msg_valid}, 32'h2);
        acc(4'b0010);
        wr(1'b0, lo(8'h60, 3'b001, 2'b11));
        chk("R6 tie without self", {28'b0, msg_valid}, 32'h4);
        acc(4'b0100);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fixed();
        t_busy_ignore();
        t_shorthand();
        t_nobody();
        t_reserved();
        t_focus();
        t_tie();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule